// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is an 8-bit up-counter advanced by a selectable prescaler tick. It can be used in two ways. In interval mode every wrap of the counter from 0xFF to 0x00 latches a sticky overflow flag, and that flag drives a level interrupt request. In watchdog mode the same wrap raises a single-cycle request instead: either a reset request or, when the variant has it and the user selects it, a non-maskable interrupt request. Software keeps the watchdog from expiring by rewriting the counter through the bus port.

The parameter `ALT` picks the variant. With `ALT = 1` the block has two prescaler chains, chosen by a source-select bit, and an auxiliary register that routes watchdog expiry to the NMI output. With `ALT = 0`, control bit 4 is reserved, only one chain exists and the NMI output never asserts.

A small controller sequences expiry handling. Its states are `ST_HALT`, `ST_RUN` and `ST_FIRE`, and its transitions are:
- **enable**: from `ST_HALT` to `ST_RUN` when the enable bit is 1.
- **disable**: from `ST_RUN` to `ST_HALT` when the enable bit is 0.
- **expire**: from `ST_RUN` to `ST_FIRE` on a watchdog-mode overflow that has a request routed to an output.
- **resume**: from `ST_FIRE` back to `ST_RUN`, or to `ST_HALT` if the enable bit has been cleared.

Top module: `wdt_timer`

## Requirements
- R1: After reset, address 0 reads 0x00 (0x10 when ALT=0), the count reads 0x00, address 2 reads 0x00, and `irq_interval`, `rst_req` and `nmi_req` are low.
- R2: While the enable bit (address 0, bit 5) is 0, the count is forced to 0x00 and stays there. Writes to the count at address 1 have no effect while the block is disabled.
- R3: While enabled, the count rises by one every 2^k clocks. The first step comes 2^k clocks after the edge that enables the block. The value k comes from clock-select bits [2:0] and source bit 4. With bit 4 = 0, select values 0..7 give k = 1,6,7,9,11,13,15,17. With bit 4 = 1 they give k = 3,4,5,8,10,12,14,16.
- R4: A step from 0xFF wraps the count to 0x00 and sets the overflow flag (address 0, bit 7).
- R5: The flag clears only when a write to address 0 with bit 7 = 0 follows a read of address 0 that saw the flag set. A write without that read leaves the flag set. Writing bit 7 = 1 never sets it. An overflow in the same cycle as a clear keeps the flag set.
- R6: With the mode bit (address 0, bit 6) at 0, `irq_interval` equals the flag, and an overflow raises neither `rst_req` nor `nmi_req`.
- R7: With the mode bit at 1, `irq_interval` stays low. An overflow gives a one-clock `rst_req` in the clock after the wrap, but only if reset-enable (address 0, bit 3) is 1 and NMI routing is off.
- R8: With ALT=1 and the NMI-route bit (address 2, bit 0) set, a watchdog-mode overflow gives a one-clock `nmi_req` instead of `rst_req`, whatever the reset-enable bit holds. The two requests are never high together.
- R9: With ALT=0, address 0 bit 4 reads 1 and ignores writes, address 2 reads 0x00, and `nmi_req` never asserts.
- R10: While enabled, a write to address 1 loads the count. When a load and a tick fall in the same clock, the load wins and no overflow occurs.
- R11: Reads are combinational on `bus_addr`. Address 0 is control, address 1 is the count, address 2 is auxiliary, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe; used only to arm flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_interval | output | 1 | Interval interrupt request (level) |
| rst_req | output | 1 | Watchdog reset request (one-clock pulse) |
| nmi_req | output | 1 | Watchdog NMI request (one-clock pulse) |

## Verification
The assertions assume that the fastest tick period is at least two clocks. This guarantees that two overflows never fall in adjacent clocks, so each request pulse is followed by a quiet clock. They also assume a bus write lasts exactly one clock, and that read and write strobes do not coincide.

The stimulus stays within these limits. It issues single-clock strobes, one at a time. Its random trials draw short prescaler taps and start counts near 0xFF, and now and then reload the count partway through a trial. A cycle-level reference model in the bench predicts every read value and request output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W   = 8;
    localparam int DIV_W   = 17;
    localparam int SHIFT_W = 5;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_AUX  = 2'd2;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_e;

    typedef enum logic {
        FIRE_RST = 1'b0,
        FIRE_NMI = 1'b1
    } fire_kind_e;

    typedef struct packed {
        logic       flag;
        logic       wd_mode;
        logic       en;
        logic       pss;
        logic       rst_en;
        logic [2:0] clk_sel;
    } ctrl_t;

    function automatic logic [SHIFT_W-1:0] tap_shift(input logic src, input logic [2:0] sel);
        logic [SHIFT_W-1:0] k;
        unique case ({src, sel})
            4'b0_000: k = 5'd1;
            4'b0_001: k = 5'd6;
            4'b0_010: k = 5'd7;
            4'b0_011: k = 5'd9;
            4'b0_100: k = 5'd11;
            4'b0_101: k = 5'd13;
            4'b0_110: k = 5'd15;
            4'b0_111: k = 5'd17;
            4'b1_000: k = 5'd3;
            4'b1_001: k = 5'd4;
            4'b1_010: k = 5'd5;
            4'b1_011: k = 5'd8;
            4'b1_100: k = 5'd10;
            4'b1_101: k = 5'd12;
            4'b1_110: k = 5'd14;
            default:  k = 5'd16;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       src,
    input  logic [2:0] clk_sel,
    output logic       tick
);

    logic [DIV_W-1:0]   div_q;
    logic [DIV_W-1:0]   mask;
    logic [SHIFT_W-1:0] k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    always_comb begin
        k    = tap_shift(src, clk_sel);
        mask = ~({DIV_W{1'b1}} << k);
        tick = run && ((div_q & mask) == mask);
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign ovf = run && tick && !load && (cnt == {CNT_W{1'b1}});

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter bit ALT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       rd_ctrl,
    input  logic       wr_aux,
    input  logic [7:0] wdata,
    input  logic       ovf,
    output ctrl_t      ctrl,
    output logic       src_eff,
    output logic       nmi_sel
);

    ctrl_t ctrl_q;
    logic  seen_q;
    logic  nmi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            seen_q <= 1'b0;
            nmi_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.wd_mode <= wdata[6];
                ctrl_q.en      <= wdata[5];
                ctrl_q.pss     <= wdata[4];
                ctrl_q.rst_en  <= wdata[3];
                ctrl_q.clk_sel <= wdata[2:0];
                seen_q         <= 1'b0;
                if (seen_q && !wdata[7]) begin
                    ctrl_q.flag <= 1'b0;
                end
            end else if (rd_ctrl && ctrl_q.flag) begin
                seen_q <= 1'b1;
            end
            if (ovf) begin
                ctrl_q.flag <= 1'b1;
            end
            if (wr_aux) begin
                nmi_q <= wdata[0];
            end
        end
    end

    generate
        if (ALT) begin : g_alt
            always_comb begin
                ctrl    = ctrl_q;
                src_eff = ctrl_q.pss;
                nmi_sel = nmi_q;
            end
        end else begin : g_base
            always_comb begin
                ctrl     = ctrl_q;
                ctrl.pss = 1'b1;
                src_eff  = 1'b0 & ctrl_q.pss;
                nmi_sel  = 1'b0 & nmi_q;
            end
        end
    endgenerate

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ovf,
    input  logic wd_mode,
    input  logic rst_en,
    input  logic nmi_sel,
    output logic rst_req,
    output logic nmi_req
);

    wdt_state_e state_q, state_d;
    fire_kind_e kind_q, kind_d;
    logic       fire_ok;

    assign fire_ok = wd_mode && (nmi_sel || rst_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            kind_q  <= FIRE_RST;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            ST_HALT: begin
                if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_HALT;
                end else if (ovf && fire_ok) begin
                    state_d = ST_FIRE;
                    kind_d  = nmi_sel ? FIRE_NMI : FIRE_RST;
                end
            end
            ST_FIRE: begin
                state_d = en ? ST_RUN : ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        rst_req = (state_q == ST_FIRE) && (kind_q == FIRE_RST);
        nmi_req = (state_q == ST_FIRE) && (kind_q == FIRE_NMI);
    end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter bit ALT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_interval,
    output logic              rst_req,
    output logic              nmi_req
);

    ctrl_t            ctrl_q;
    logic             src_eff;
    logic             nmi_sel;
    logic             tick;
    logic             ovf;
    logic             load;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ctrl, rd_ctrl, wr_aux;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign rd_ctrl = bus_rd && (bus_addr == A_CTRL);
    assign wr_aux  = bus_wr && (bus_addr == A_AUX);
    assign load    = bus_wr && (bus_addr == A_CNT) && ctrl_q.en;

    wdt_regs #(.ALT(ALT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .rd_ctrl (rd_ctrl),
        .wr_aux  (wr_aux),
        .wdata   (bus_wdata),
        .ovf     (ovf),
        .ctrl    (ctrl_q),
        .src_eff (src_eff),
        .nmi_sel (nmi_sel)
    );

    wdt_prescaler u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.en),
        .src     (src_eff),
        .clk_sel (ctrl_q.clk_sel),
        .tick    (tick)
    );

    wdt_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.en),
        .tick     (tick),
        .load     (load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt_q),
        .ovf      (ovf)
    );

    wdt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q.en),
        .ovf     (ovf),
        .wd_mode (ctrl_q.wd_mode),
        .rst_en  (ctrl_q.rst_en),
        .nmi_sel (nmi_sel),
        .rst_req (rst_req),
        .nmi_req (nmi_req)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_CNT:   bus_rdata = cnt_q;
            A_AUX:   bus_rdata = {7'd0, nmi_sel};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq_interval = ctrl_q.flag && !ctrl_q.wd_mode;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter bit ALT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       wd_mode,
    input logic       flag,
    input logic       tick,
    input logic       load,
    input logic [7:0] cnt,
    input logic       ovf,
    input logic       rst_req,
    input logic       nmi_req
);

    // R2: disabled counter sits at zero
    a_r2_halt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (cnt == 8'h00));

    // R3: each accepted tick advances the count by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !load && (cnt != 8'hFF)) |=> (cnt == 8'($past(cnt) + 8'd1)));

    // R4: wrap to zero and flag set
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ((cnt == 8'h00) && flag));

    // R6: interval-mode overflow requests nothing
    a_r6_interval_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wd_mode) |=> (!rst_req && !nmi_req));

    // R7: reset request lasts one clock
    a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: any request follows a watchdog-mode overflow
    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || nmi_req) |-> ($past(ovf) && $past(wd_mode)));

    // R8: requests are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req, nmi_req}));

    generate
        if (!ALT) begin : g_base
            // R9: base variant never raises NMI
            a_r9_no_nmi: assert property (@(posedge clk) disable iff (!rst_n)
                !nmi_req);
        end
    endgenerate

endmodule

bind wdt_timer wdt_checker #(.ALT(ALT)) u_wdt_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q.en),
    .wd_mode (ctrl_q.wd_mode),
    .flag    (ctrl_q.flag),
    .tick    (tick),
    .load    (load),
    .cnt     (cnt_q),
    .ovf     (ovf),
    .rst_req (rst_req),
    .nmi_req (nmi_req)
);

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] addr;
    logic       wr, rd;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq, rreq, nreq;

    logic [1:0] v0_addr;
    logic       v0_wr, v0_rd;
    logic [7:0] v0_wdata;
    logic [7:0] v0_rdata;
    logic       v0_irq, v0_rreq, v0_nreq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit       m_en, m_mode, m_pss, m_rsten, m_flag, m_seen, m_nmi;
    bit [2:0] m_sel;
    bit [7:0] m_cnt;
    int       m_div;
    bit       e_rst, e_nmi;

    always #10 clk = ~clk;

    wdt_timer #(.ALT(1'b1)) u_wdt_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_interval(irq),
        .rst_req(rreq), .nmi_req(nreq)
    );

    wdt_timer #(.ALT(1'b0)) u_wdt_timer_v0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(v0_addr), .bus_wr(v0_wr), .bus_rd(v0_rd),
        .bus_wdata(v0_wdata), .bus_rdata(v0_rdata), .irq_interval(v0_irq),
        .rst_req(v0_rreq), .nmi_req(v0_nreq)
    );

    function automatic int k_of(input bit src, input bit [2:0] sel);
        int t0 [8] = '{1, 6, 7, 9, 11, 13, 15, 17};
        int t1 [8] = '{3, 4, 5, 8, 10, 12, 14, 16};
        return src ? t1[sel] : t0[sel];
    endfunction

    function automatic bit [7:0] exp_read(input bit [1:0] a);
        case (a)
            2'd0:    return {m_flag, m_mode, m_en, m_pss, m_rsten, m_sel};
            2'd1:    return m_cnt;
            2'd2:    return {7'd0, m_nmi};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input bit [10:0] got, input bit [10:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_update();
        int  p;
        bit  tk, ld, ov, nf, ns;
        p  = 1 << k_of(m_pss, m_sel);
        tk = m_en && ((m_div % p) == p - 1);
        ld = wr && (addr == 2'd1) && m_en;
        ov = tk && !ld && (m_cnt == 8'hFF);
        e_rst = ov && m_mode && !m_nmi && m_rsten;
        e_nmi = ov && m_mode && m_nmi;
        nf = m_flag;
        ns = m_seen;
        if (wr && addr == 2'd0) begin
            ns = 1'b0;
            if (m_seen && !wdata[7]) nf = 1'b0;
        end else if (rd && addr == 2'd0 && m_flag) begin
            ns = 1'b1;
        end
        if (ov) nf = 1'b1;
        if (!m_en)    m_cnt = 8'h00;
        else if (ld)  m_cnt = wdata;
        else if (tk)  m_cnt = m_cnt + 8'd1;
        m_div  = m_en ? m_div + 1 : 0;
        m_flag = nf;
        m_seen = ns;
        if (wr && addr == 2'd0) begin
            m_mode  = wdata[6];
            m_en    = wdata[5];
            m_pss   = wdata[4];
            m_rsten = wdata[3];
            m_sel   = wdata[2:0];
        end
        if (wr && addr == 2'd2) m_nmi = wdata[0];
    endtask

    task automatic check_main();
        check(cur_req, {rdata, irq, rreq, nreq},
              {exp_read(addr), m_flag && !m_mode, e_rst, e_nmi});
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_main();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_reg(input bit [1:0] a, input bit [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rd_reg(input bit [1:0] a);
        addr = a; rd = 1'b1;
        cyc();
        rd = 1'b0;
    endtask

    task automatic v0_wr_reg(input bit [1:0] a, input bit [7:0] d);
        v0_addr = a; v0_wdata = d; v0_wr = 1'b1;
        cyc();
        v0_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int rst_seen, nmi_seen;
        void'($urandom(32'h5EED));
        addr = 2'd0; wr = 1'b0; rd = 1'b0; wdata = 8'h00;
        v0_addr = 2'd0; v0_wr = 1'b0; v0_rd = 1'b0; v0_wdata = 8'h00;
        m_en = 0; m_mode = 0; m_pss = 0; m_rsten = 0; m_flag = 0; m_seen = 0; m_nmi = 0;
        m_sel = 3'd0; m_cnt = 8'h00; m_div = 0; e_rst = 0; e_nmi = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        check_main();
        check("R1", {3'b0, v0_rdata, v0_irq, v0_rreq, v0_nreq}, {3'b0, 8'h10, 3'b000});
        addr = 2'd1; #1 check_main();
        addr = 2'd2; #1 check_main();

        // R2: count write ignored while disabled
        cur_req = "R2";
        wr_reg(2'd1, 8'h55);
        addr = 2'd1; idle(3);

        // R11: unused address reads zero
        cur_req = "R11";
        addr = 2'd3; idle(2);

        // R3: enable with divide by two, watch steps
        cur_req = "R3";
        wr_reg(2'd0, 8'h20);
        addr = 2'd1; idle(20);
        wr_reg(2'd0, 8'h31);
        addr = 2'd1; idle(40);

        // R10: reload near the top, interval overflow
        cur_req = "R10";
        wr_reg(2'd0, 8'h20);
        wr_reg(2'd1, 8'hFE);
        cur_req = "R4";
        addr = 2'd1; idle(8);
        // R6: interval irq follows flag
        cur_req = "R6";
        addr = 2'd0; idle(3);

        // R5: write without prior read keeps flag; bit7=1 does not clear
        cur_req = "R5";
        wr_reg(2'd0, 8'h20);
        idle(2);
        rd_reg(2'd0);
        wr_reg(2'd0, 8'hA0);
        rd_reg(2'd0);
        wr_reg(2'd0, 8'h20);
        idle(2);

        // R7: watchdog reset pulse
        cur_req = "R7";
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd0, 8'h68);
        wr_reg(2'd1, 8'hFD);
        addr = 2'd0; idle(12);
        // R7: reset-enable off gives no pulse
        wr_reg(2'd0, 8'h60);
        wr_reg(2'd1, 8'hFD);
        idle(12);

        // R8: NMI routing
        cur_req = "R8";
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd1, 8'hFD);
        addr = 2'd2; idle(12);

        // R9: base variant reserved bit and no NMI
        cur_req = "R9";
        v0_wr_reg(2'd0, 8'h00);
        v0_addr = 2'd0; #1
        check("R9", {3'b0, v0_rdata}, {3'b0, 8'h10});
        v0_wr_reg(2'd2, 8'h01);
        v0_addr = 2'd2; #1
        check("R9", {3'b0, v0_rdata}, 11'h000);
        v0_wr_reg(2'd0, 8'h68);
        v0_wr_reg(2'd1, 8'hFE);
        rst_seen = 0; nmi_seen = 0;
        for (int i = 0; i < 12; i++) begin
            cyc();
            rst_seen += int'(v0_rreq);
            nmi_seen += int'(v0_nreq);
        end
        check("R9", 11'(rst_seen * 16 + nmi_seen), 11'(16));
        v0_wr_reg(2'd0, 8'h00);

        // R3 R7 R8: constrained random trials
        for (int t = 0; t < 24; t++) begin
            bit       src, md, re, nm;
            bit [2:0] sl;
            bit [7:0] st, cw;
            int       p, n;
            cur_req = "R3";
            src = 1'($urandom % 2);
            sl  = src ? 3'($urandom % 3) : 3'($urandom % 2);
            md  = 1'($urandom % 2);
            re  = 1'($urandom % 2);
            nm  = 1'($urandom % 2);
            st  = 8'hE0 | 8'($urandom % 32);
            cw  = {1'b0, md, 1'b1, src, re, sl};
            wr_reg(2'd0, 8'h00);
            wr_reg(2'd2, {7'd0, nm});
            rd_reg(2'd0);
            wr_reg(2'd0, cw);
            wr_reg(2'd1, st);
            cur_req = md ? (nm ? "R8" : "R7") : "R6";
            addr = 2'(t % 3);
            p = 1 << k_of(src, sl);
            n = (256 - int'(st)) * p + p + 4;
            if (($urandom % 4) == 0) begin
                idle(n / 2);
                cur_req = "R10";
                wr_reg(2'd1, st);
                addr = 2'd1;
            end
            idle(n);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule